// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

A bank of identical timer channels, each driving one pulse-width-modulated output. Every channel holds a 16-bit up-counter, a duty compare value, a period compare value and a three-bit control field. A channel advances its counter on its own tick-enable input, but only while its run bit is set. The output sits at a programmable initial level until the counter reaches the duty value. From there to the period value it takes the opposite level. On the tick that finds the counter equal to the period, the counter wraps to zero.

Software reaches the bank through a plain synchronous port: address, write data, write strobe and combinational read data. Run bits are changed through a write-one-to-start register and a write-one-to-stop register, so one channel can be started or stopped without a read-modify-write of the others. When the output enable is removed, the output either falls back to the initial level at once or finishes the period in progress first, depending on a per-channel shutdown-mode bit.

Top module: `pwm_timer_bank`

## Requirements
- R1: A running channel's counter rises by one on each cycle its tick is high. On a tick when it equals the period value, it becomes 0 instead.
- R2: With output enable set and duty <= period, the output is the initial level while count < duty and the inverted initial level while count >= duty.
- R3: Control bit 1 sets the initial level (1 = high, 0 = low) and so sets the polarity of the whole waveform.
- R4: With control bit 0 (output enable) clear and no period still completing, the output drives the initial level whatever the counter does.
- R5: The address has its top bit set for the shared registers. Writing offset 0 there sets run bit n for each 1 in bit n of the data. Writing offset 1 clears run bit n for each 1 in bit n. Zero bits leave run bits unchanged.
- R6: Software can write the counter at channel offset 3. That write takes priority over a tick in the same cycle.
- R7: When duty > period, the output never leaves the initial level.
- R8: With control bit 2 set, clearing output enable returns the output to the initial level in the cycle after the write.
- R9: With control bit 2 clear, clearing output enable lets the waveform run on until the counter wraps (or stops). After that the output holds the initial level.
- R10: Channel space has a top address bit of 0, with the channel number in bits [AW-2:2]. Its offsets read back control (0, bits [2:0]), duty (1), period (2) and count (3). Shared offset 2 reads the run bits.
- R11: After reset, all counters, compare values, control bits and run bits are 0, and every output is low.
- R12: A counter whose run bit is clear keeps its value regardless of its tick input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | NCH | Per-channel count enable |
| bus_addr | input | AW | Register address (AW = clog2(NCH)+3) |
| bus_wdata | input | CW | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | CW | Read data for bus_addr, combinational |
| pwm_out | output | NCH | PWM outputs, one per channel |

## Verification
A corrupted counter shows within one tick, as a wrong readback at offset 3 and as an output edge at the wrong count. This holds because the output is a direct function of the registered counter and compare values. A stuck hold flag in the deferred-shutdown path shows one cycle after the wrap, when the output should have returned to its initial level. A wrong run bit shows immediately in the status register. It also shows as a counter that moves, or fails to move, on the next tick.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    CREG_CTRL   = 2'd0,
    CREG_DUTY   = 2'd1,
    CREG_PERIOD = 2'd2,
    CREG_COUNT  = 2'd3
  } chan_reg_e;

  typedef enum logic [1:0] {
    GREG_START  = 2'd0,
    GREG_STOP   = 2'd1,
    GREG_STATUS = 2'd2,
    GREG_NONE   = 2'd3
  } glob_reg_e;

  localparam int CTL_W    = 3;
  localparam int CTL_EN   = 0;
  localparam int CTL_INIT = 1;
  localparam int CTL_SD   = 2;

endpackage

// File: rtl/pwm_timer_rstsync.sv
module pwm_timer_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pwm_timer_wave.sv
module pwm_timer_wave #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] period,
  input  logic          out_en,
  input  logic          init_lvl,
  input  logic          abrupt,
  input  logic          run,
  input  logic          wrap,
  output logic          out
);

  logic hold_q, hold_d;
  logic phase, drive;

  // Deferred-shutdown flag: set while enabled, dropped at the end of the period
  always_comb begin
    if (out_en)                    hold_d = 1'b1;
    else if (abrupt || wrap || !run) hold_d = 1'b0;
    else                           hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    phase = (cnt >= duty) && (duty <= period);
    drive = out_en || (hold_q && !abrupt);
    out   = drive ? (init_lvl ^ phase) : init_lvl;
  end

  AST_DUTY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (duty > period) |-> (out == init_lvl)); // R7
  AST_ABRUPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && abrupt) |-> (out == init_lvl)); // R8
  AST_DEFER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !out_en) |=> (out_en || out == init_lvl)); // R9

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_en,
  input  chan_reg_e     wr_sel,
  input  logic [CW-1:0] wdata,
  input  chan_reg_e     rd_sel,
  output logic [CW-1:0] rdata,
  output logic          out
);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    duty_q, duty_d;
  logic [CW-1:0]    period_q, period_d;
  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic             cnt_wr, wrap;

  always_comb begin
    cnt_wr   = wr_en && (wr_sel == CREG_COUNT);
    wrap     = run && tick && !cnt_wr && (cnt_q == period_q);
    cnt_d    = cnt_q;
    duty_d   = duty_q;
    period_d = period_q;
    ctrl_d   = ctrl_q;
    if (cnt_wr)           cnt_d = wdata;
    else if (wrap)        cnt_d = '0;
    else if (run && tick) cnt_d = cnt_q + 1'b1;
    if (wr_en && wr_sel == CREG_DUTY)   duty_d   = wdata;
    if (wr_en && wr_sel == CREG_PERIOD) period_d = wdata;
    if (wr_en && wr_sel == CREG_CTRL)   ctrl_d   = wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      duty_q   <= '0;
      period_q <= '0;
      ctrl_q   <= '0;
    end else begin
      cnt_q    <= cnt_d;
      duty_q   <= duty_d;
      period_q <= period_d;
      ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (rd_sel)
      CREG_CTRL:   rdata[CTL_W-1:0] = ctrl_q;
      CREG_DUTY:   rdata = duty_q;
      CREG_PERIOD: rdata = period_q;
      CREG_COUNT:  rdata = cnt_q;
    endcase
  end

  pwm_timer_wave #(.CW(CW)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_q),
    .duty     (duty_q),
    .period   (period_q),
    .out_en   (ctrl_q[CTL_EN]),
    .init_lvl (ctrl_q[CTL_INIT]),
    .abrupt   (ctrl_q[CTL_SD]),
    .run      (run),
    .wrap     (wrap),
    .out      (out)
  );

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_wr && cnt_q != period_q) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q)); // R12
  AST_SW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata))); // R6

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tick,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  input  logic           bus_we,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);

  logic           rst_sync_n;
  logic [NCH-1:0] run_q, run_d;
  logic           glob_space;
  logic [CHW-1:0] ch_idx;
  logic           ch_valid;
  chan_reg_e      ch_reg;
  glob_reg_e      g_reg;
  logic           start_wr, stop_wr;
  logic [CW-1:0]  ch_rdata [NCH];

  pwm_timer_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    glob_space = bus_addr[AW-1];
    ch_idx     = bus_addr[AW-2:2];
    ch_valid   = !glob_space && (int'(ch_idx) < NCH);
    ch_reg     = chan_reg_e'(bus_addr[1:0]);
    g_reg      = glob_reg_e'(bus_addr[1:0]);
    start_wr   = bus_we && glob_space && (g_reg == GREG_START);
    stop_wr    = bus_we && glob_space && (g_reg == GREG_STOP);
  end

  always_comb begin
    run_d = run_q;
    if (start_wr) run_d = run_q | bus_wdata[NCH-1:0];
    if (stop_wr)  run_d = run_q & ~bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= '0;
    else             run_q <= run_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel_wr;
    assign sel_wr = bus_we && ch_valid && (int'(ch_idx) == g);
    pwm_timer_chan #(.CW(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick   (tick[g]),
      .run    (run_q[g]),
      .wr_en  (sel_wr),
      .wr_sel (ch_reg),
      .wdata  (bus_wdata),
      .rd_sel (ch_reg),
      .rdata  (ch_rdata[g]),
      .out    (pwm_out[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (glob_space) begin
      if (g_reg == GREG_STATUS) bus_rdata[NCH-1:0] = run_q;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (int'(ch_idx) == i) bus_rdata = ch_rdata[i];
    end
  end

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_wr |=> ((run_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0]))); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_wr |=> ((run_q & $past(bus_wdata[NCH-1:0])) == '0)); // R5
  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_wr && !stop_wr) |=> $stable(run_q)); // R5

endmodule

// File: tb/pwm_timer_bank_bench.sv
module pwm_timer_bank_bench;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = $clog2(NCH) + 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] tick;
  logic [AW-1:0]  bus_addr;
  logic [CW-1:0]  bus_wdata;
  logic           bus_we;
  logic [CW-1:0]  bus_rdata;
  logic [NCH-1:0] pwm_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_timer_bank #(.NCH(NCH), .CW(CW)) u_pwm_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] caddr(input int ch, input int r);
    return AW'((ch << 2) | r);
  endfunction

  function automatic logic [AW-1:0] gaddr(input int sel);
    return AW'((1 << (AW - 1)) | sel);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tk(input int n);
    tick = '1;
    repeat (n) @(negedge clk);
    tick = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] v, v2;
    int m;
    rst_n = 1'b0; tick = '0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11 outputs low", 32'(pwm_out), 0);
    rd(gaddr(2), v); check("R11 status", 32'(v), 0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) begin
        rd(caddr(c, r), v); check("R11 register", 32'(v), 0);
      end

    // R1 R2 R3 R7: sweep duty and initial level, period 4
    for (int il = 0; il < 2; il++)
      for (int duty = 0; duty <= 6; duty++) begin
        int c;
        int p;
        c = duty % NCH;
        p = 4;
        wr(gaddr(1), CW'(1 << c));
        wr(caddr(c, 3), 0);
        wr(caddr(c, 1), CW'(duty));
        wr(caddr(c, 2), CW'(p));
        wr(caddr(c, 0), CW'(1 | (il << 1) | 4));
        wr(gaddr(0), CW'(1 << c));
        m = 0;
        for (int k = 0; k < 13; k++) begin
          logic e;
          e = (duty <= p && m >= duty) ? ~il[0] : il[0];
          check(duty > p ? "R7 parked" : (il != 0 ? "R3 waveform" : "R2 waveform"),
                32'(pwm_out[c]), 32'(e));
          tick = '1;
          @(negedge clk);
          m = (m == p) ? 0 : m + 1;
        end
        tick = '0;
        rd(caddr(c, 3), v); check("R1 count wrap", 32'(v), 32'(m));
      end

    // R4: enable clear, initial level high, counter running
    wr(gaddr(1), 4'hF);
    wr(caddr(0, 3), 0); wr(caddr(0, 1), 1); wr(caddr(0, 2), 3);
    wr(caddr(0, 0), 16'h6);
    wr(gaddr(0), 1);
    for (int k = 0; k < 6; k++) begin
      check("R4 disabled output", 32'(pwm_out[0]), 1);
      tick = '1; @(negedge clk);
    end
    tick = '0;

    // R6: software count write beats a tick
    tick = '1; wr(caddr(0, 3), 9); tick = '0;
    rd(caddr(0, 3), v); check("R6 count write", 32'(v), 9);

    // R12: stopped counter holds
    rd(caddr(1, 3), v);
    tk(3);
    rd(caddr(1, 3), v2); check("R12 stopped count", 32'(v2), 32'(v));

    // R5 R10: start/stop registers
    wr(gaddr(1), 4'hF); rd(gaddr(2), v); check("R5 stop all", 32'(v), 0);
    wr(gaddr(0), 4'h5); rd(gaddr(2), v); check("R5 start", 32'(v), 5);
    wr(gaddr(1), 4'h4); rd(gaddr(2), v); check("R5 stop one", 32'(v), 1);
    wr(gaddr(0), 4'h0); rd(gaddr(2), v); check("R5 zero start", 32'(v), 1);
    wr(gaddr(1), 4'h0); rd(gaddr(2), v); check("R5 zero stop", 32'(v), 1);

    // R10: readback
    wr(caddr(3, 1), 16'hBEEF); rd(caddr(3, 1), v); check("R10 duty", 32'(v), 32'hBEEF);
    wr(caddr(3, 2), 16'h1234); rd(caddr(3, 2), v); check("R10 period", 32'(v), 32'h1234);
    wr(caddr(3, 0), 16'hFFFF); rd(caddr(3, 0), v); check("R10 ctrl", 32'(v), 7);

    // R9 R8: deferred and abrupt shutdown on channel 2
    wr(gaddr(1), 4'h4);
    wr(caddr(2, 3), 0); wr(caddr(2, 1), 2); wr(caddr(2, 2), 5);
    wr(caddr(2, 0), 1);
    wr(gaddr(0), 4'h4);
    tk(3);
    check("R2 active phase", 32'(pwm_out[2]), 1);
    wr(caddr(2, 0), 0);
    check("R9 held after disable", 32'(pwm_out[2]), 1);
    tk(1); check("R9 count 4", 32'(pwm_out[2]), 1);
    tk(1); check("R9 count 5", 32'(pwm_out[2]), 1);
    tk(1); check("R9 wrapped", 32'(pwm_out[2]), 0);
    tk(2); check("R9 idle after wrap", 32'(pwm_out[2]), 0);
    wr(caddr(2, 0), 1);
    check("R2 re-enable", 32'(pwm_out[2]), 1);
    wr(caddr(2, 0), 4);
    check("R8 abrupt off", 32'(pwm_out[2]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule